// File: doc/BRIEF.md
# Critical-Word-First Line Fill Engine

This block handles misses for a small blocking cache whose lines hold eight 32-bit words. When an access misses, it sends one burst request to memory that starts at the missed word and wraps around the end of the line. It hands that word to the CPU in the same cycle it arrives, so the CPU can resume at once. The remaining words then fill the data array while the CPU keeps working. A second mode fetches the line in plain order from word 0. In that mode the CPU is still released on the cycle its word arrives, not when the line is complete.

The block keeps one filled bit per word of the line being fetched. An access to that line is answered from any word already in the array, or from the bus in the cycle its word arrives. Otherwise it waits. Valid lines elsewhere in the cache keep hitting during a fill. A miss to any other line waits until the fill has finished. The tag and valid bit of a line are written only with its last word. The old contents at that index stop hitting as soon as the fill begins.

Top module: `cwf_fill`

## Requirements
- R1: While rst_n is low, cpu_ack and mem_req stay low. Every line is invalid, so the first access after reset misses.
- R2: A miss seen while no fill is running raises mem_req for exactly one cycle, in the cycle after the miss. mem_addr then holds the line's tag and index with the start offset in the low word bits. A word address splits into offset [2:0], index [IDX_W+2:3] and tag above that.
- R3: With wrap_en high the start offset is the offset of the missed word. With wrap_en low it is 0.
- R4: Memory returns eight beats on mem_rvalid, and beat i carries word (start + i) mod 8 of the line. Every word ends up stored at its own offset.
- R5: The missed word is acknowledged in the same cycle as its beat on mem_rvalid, with cpu_rdata equal to mem_rdata. This holds in both modes.
- R6: An access to the line being filled is acknowledged at once if its word is already filled, or in the cycle its beat arrives. Until then it stalls.
- R7: The line's tag and valid bit are written with the last beat. From the next cycle every word of the line hits without a new mem_req.
- R8: When a fill starts, the line previously held at that index stops hitting. An access to it stalls during the fill and is then handled as a new miss.
- R9: A miss to a different line during a fill stalls, and mem_req stays low until the fill completes. The miss is then served with a new request.
- R10: During a fill, an access that hits another valid line is acknowledged in the same cycle.
- R11: With no fill running, a hit is acknowledged in the same cycle it is presented, with the stored word, and mem_req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrap_en | input | 1 | 1: start the burst at the missed word and wrap; 0: start at word 0 |
| cpu_req | input | 1 | CPU read request, held until acknowledged |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_ack | output | 1 | Read data valid; the request is complete |
| cpu_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | One-cycle burst request |
| mem_addr | output | ADDR_W | Word address of the first beat |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | DATA_W | Burst beat data |

## Verification
A miss presented in cycle c raises mem_req in cycle c+1. With a fixed memory delay L, the missed word's beat falls in cycle c+1+L when wrapping, or c+1+L+offset in plain order. cpu_ack is combinational, so it is due in that same beat cycle. Hits, filled words and a word arriving in the current cycle are due in the cycle they are presented. After the last beat in cycle B, a stalled miss can restart no earlier than B+1. The bench numbers cycles by rising edges, drives its inputs on falling edges and samples 1 ns after them. It compares each acknowledge cycle against these formulas exactly, and compares each stalled acknowledge against the recorded last-beat cycle.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_state_t;
endpackage

// File: rtl/cwf_seq.sv
// Burst position sequencer: start offset plus beat count, wrapping in the line.
module cwf_seq #(
  parameter int WORDS = 8,
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic             advance,
  output logic [OFS_W-1:0] pos,
  output logic             last
);
  logic [OFS_W-1:0] base_q, base_d;
  logic [OFS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (start) begin
      base_d = start_ofs;
      cnt_d  = '0;
    end else if (advance) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (start || advance) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // WORDS is a power of two, so the modulo is the natural wrap of OFS_W bits.
  assign pos  = base_q + cnt_q;
  assign last = (cnt_q == OFS_W'(WORDS - 1));
endmodule

// File: rtl/cwf_track.sv
// Per-word filled bits for the line under fill.
module cwf_track #(
  parameter int WORDS = 8,
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             set,
  input  logic [OFS_W-1:0] set_pos,
  output logic [WORDS-1:0] filled
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic bit_q, bit_d, bit_en;

    always_comb begin
      bit_en = clear || (set && (set_pos == OFS_W'(g)));
      bit_d  = !clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign filled[g] = bit_q;
  end
endmodule

// File: rtl/cwf_store.sv
// Data array with tag and valid per line; read side is combinational.
module cwf_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFS_W-1:0]  wr_pos,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inval_en,
  input  logic [IDX_W-1:0]  inval_idx,
  input  logic              commit_en,
  input  logic [IDX_W-1:0]  commit_idx,
  input  logic [TAG_W-1:0]  commit_tag,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFS_W-1:0]  rd_pos,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] arr_q [LINES*WORDS];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINES-1:0]  valid_q, valid_d;

  always_ff @(posedge clk) begin
    if (wr_en) arr_q[{wr_idx, wr_pos}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (commit_en) tag_q[commit_idx] <= commit_tag;
  end

  always_comb begin
    valid_d = valid_q;
    if (inval_en)  valid_d[inval_idx]  = 1'b0;
    if (commit_en) valid_d[commit_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      valid_q <= '0;
    else if (inval_en || commit_en)  valid_q <= valid_d;
  end

  assign rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data = arr_q[{rd_idx, rd_pos}];
endmodule

// File: rtl/cwf_fill.sv
module cwf_fill #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_en,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  import cwf_pkg::*;

  localparam int OFS_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFS_W - IDX_W;

  logic [OFS_W-1:0] c_ofs;
  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag;

  assign c_ofs = cpu_addr[OFS_W-1:0];
  assign c_idx = cpu_addr[OFS_W +: IDX_W];
  assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  fill_state_t      state_q, state_d;
  logic [IDX_W-1:0] fill_idx_q;
  logic [TAG_W-1:0] fill_tag_q;
  logic             mem_req_q;
  logic [ADDR_W-1:0] mem_addr_q, mem_addr_d;

  logic             fill_busy;
  logic             beat_in;
  logic [OFS_W-1:0] beat_pos;
  logic             beat_last;
  logic [WORDS-1:0] filled;
  logic             stored_hit;
  logic [DATA_W-1:0] stored_data;
  logic             same_line;
  logic             bypass;
  logic             filled_hit;
  logic             start_miss;
  logic             fill_done;
  logic [OFS_W-1:0] start_ofs;

  assign fill_busy  = (state_q == FS_FILL);
  assign beat_in    = fill_busy && mem_rvalid;
  assign fill_done  = beat_in && beat_last;
  assign same_line  = fill_busy && (c_idx == fill_idx_q) && (c_tag == fill_tag_q);
  assign bypass     = same_line && beat_in && (beat_pos == c_ofs);
  assign filled_hit = same_line && filled[c_ofs];
  assign start_miss = !fill_busy && cpu_req && !stored_hit;
  assign start_ofs  = wrap_en ? c_ofs : '0;

  assign cpu_ack   = cpu_req && (stored_hit || bypass || filled_hit);
  assign cpu_rdata = bypass ? mem_rdata : stored_data;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE: if (start_miss) state_d = FS_FILL;
      FS_FILL: if (fill_done)  state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
    mem_addr_d = {c_tag, c_idx, start_ofs};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      mem_req_q  <= 1'b0;
      fill_idx_q <= '0;
      fill_tag_q <= '0;
      mem_addr_q <= '0;
    end else begin
      state_q   <= state_d;
      mem_req_q <= start_miss;
      if (start_miss) begin
        fill_idx_q <= c_idx;
        fill_tag_q <= c_tag;
        mem_addr_q <= mem_addr_d;
      end
    end
  end

  assign mem_req  = mem_req_q;
  assign mem_addr = mem_addr_q;

  cwf_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_miss),
    .start_ofs (start_ofs),
    .advance   (beat_in),
    .pos       (beat_pos),
    .last      (beat_last)
  );

  cwf_track #(.WORDS(WORDS)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_miss),
    .set     (beat_in),
    .set_pos (beat_pos),
    .filled  (filled)
  );

  cwf_store #(
    .LINES  (LINES),
    .WORDS  (WORDS),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (beat_in),
    .wr_idx     (fill_idx_q),
    .wr_pos     (beat_pos),
    .wr_data    (mem_rdata),
    .inval_en   (start_miss),
    .inval_idx  (c_idx),
    .commit_en  (fill_done),
    .commit_idx (fill_idx_q),
    .commit_tag (fill_tag_q),
    .rd_idx     (c_idx),
    .rd_pos     (c_ofs),
    .rd_tag     (c_tag),
    .rd_hit     (stored_hit),
    .rd_data    (stored_data)
  );
endmodule

// File: rtl/cwf_fill_chk.sv
module cwf_fill_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFS_W  = 3,
  parameter int TAG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ack,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              fill_busy,
  input logic [OFS_W-1:0]  beat_pos,
  input logic [IDX_W-1:0]  fill_idx_q,
  input logic [TAG_W-1:0]  fill_tag_q
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (!mem_req && !cpu_ack);
  end

  // R2
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R9
  a_r9_no_req_mid_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_busy && $past(fill_busy)) |-> !mem_req);

  // R5
  a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_busy && mem_rvalid && cpu_req &&
     (cpu_addr == {fill_tag_q, fill_idx_q, beat_pos}))
    |-> (cpu_ack && (cpu_rdata == mem_rdata)));

  // R6
  a_r6_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> cpu_req);

  // R7
  a_r7_commit_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fill_busy) |-> $past(mem_rvalid));
endmodule

bind cwf_fill cwf_fill_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W),
  .OFS_W  (OFS_W),
  .TAG_W  (TAG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_addr   (cpu_addr),
  .cpu_ack    (cpu_ack),
  .cpu_rdata  (cpu_rdata),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .mem_rdata  (mem_rdata),
  .fill_busy  (fill_busy),
  .beat_pos   (beat_pos),
  .fill_idx_q (fill_idx_q),
  .fill_tag_q (fill_tag_q)
);

// File: tb/sim_cwf_fill.sv
`timescale 1ns/1ps
module sim_cwf_fill;
  localparam int AW  = 10;
  localparam int DW  = 32;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wrap_en;
  logic          cpu_req;
  logic [AW-1:0] cpu_addr;
  logic          cpu_ack;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid;
  logic [DW-1:0] mem_rdata;

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int req_count = 0;
  int last_req_addr = 0;
  int last_beat_cyc = 0;
  bit mem_busy = 1'b0;
  bit gap_en = 1'b0;
  bit done = 1'b0;

  cwf_fill u0 (
    .clk(clk), .rst_n(rst_n), .wrap_en(wrap_en),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] mdata(input int a);
    return 32'hC0DE0000 | DW'(a * 7);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: beat i of a burst is word (start+i) mod 8, first beat LAT cycles after mem_req.
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        int base, st;
        req_count++;
        last_req_addr = int'(mem_addr);
        mem_busy = 1'b1;
        base = int'(mem_addr) & ~7;
        st   = int'(mem_addr) & 7;
        repeat (LAT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          if (gap_en && (i % 3 == 1)) begin
            mem_rvalid = 1'b0;
            @(negedge clk);
          end
          mem_rvalid = 1'b1;
          mem_rdata  = mdata(base + ((st + i) & 7));
          if (i == 7) last_beat_cyc = cyc;
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
        mem_busy = 1'b0;
      end
    end
  end

  task automatic access(input int a, output int pres, output int ackc, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_req  = 1'b1;
    cpu_addr = AW'(a);
    pres = cyc;
    ackc = -1;
    d = '0;
    forever begin
      #1;
      if (cpu_ack) begin
        ackc = cyc;
        d = cpu_rdata;
        break;
      end
      if (cyc - pres > 300) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    cpu_req = 1'b0;
    while (mem_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int p, k, c0, rc;
    logic [DW-1:0] d;
    rst_n = 1'b0;
    wrap_en = 1'b1;
    cpu_req = 1'b1;
    cpu_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!cpu_ack && !mem_req, "R1 quiet in reset", {cpu_ack, mem_req}, 0);
    @(negedge clk);
    cpu_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Wrap mode, line tag1 idx0, miss at offset 5
    access(37, c0, k, d);
    chk(k == c0 + 1 + LAT, "R5 critical word cycle", k, c0 + 1 + LAT);
    chk(d == mdata(37), "R5 critical word data", d, mdata(37));
    chk(last_req_addr == 37, "R2 R3 burst start address", last_req_addr, 37);
    chk(req_count == 1, "R1 first access misses", req_count, 1);
    access(38, p, k, d);
    chk(k == p && d == mdata(38), "R6 word arriving now", k, p);
    access(36, p, k, d);
    chk(k == c0 + 1 + LAT + 7, "R6 R4 stall to wrapped last beat", k, c0 + 1 + LAT + 7);
    chk(d == mdata(36), "R6 stalled data", d, mdata(36));
    for (int w = 0; w < 8; w++) begin
      access(32 + w, p, k, d);
      chk(k == p, "R7 R11 hit same cycle", k, p);
      chk(d == mdata(32 + w), "R4 word placement", d, mdata(32 + w));
    end
    chk(req_count == 1, "R11 no request on hits", req_count, 1);
    wait_idle();

    // Natural mode, tag2 idx1 offset 3
    wrap_en = 1'b0;
    access(75, c0, k, d);
    chk(last_req_addr == 72, "R3 natural start at 0", last_req_addr, 72);
    chk(k == c0 + 1 + LAT + 3, "R5 natural early release", k, c0 + 1 + LAT + 3);
    chk(d == mdata(75), "R5 natural data", d, mdata(75));
    access(73, p, k, d);
    chk(k == p && d == mdata(73), "R6 already filled word", k, p);
    access(79, p, k, d);
    chk(k == c0 + 1 + LAT + 7 && d == mdata(79), "R6 natural stall", k, c0 + 1 + LAT + 7);
    wait_idle();

    // Hit under fill and miss stalled by fill
    wrap_en = 1'b1;
    gap_en = 1'b1;
    access(112, c0, k, d);
    chk(d == mdata(112), "R5 gapped critical data", d, mdata(112));
    access(37, p, k, d);
    chk(k == p && d == mdata(37), "R10 hit other line during fill", k, p);
    rc = req_count;
    access(154, p, k, d);
    chk(k > last_beat_cyc, "R9 miss waits for fill end", k, last_beat_cyc + 1);
    chk(req_count == rc + 1 && last_req_addr == 154, "R9 new request after fill", last_req_addr, 154);
    chk(d == mdata(154), "R9 data", d, mdata(154));
    wait_idle();
    gap_en = 1'b0;

    // Eviction: tag5 idx0 replaces line A
    access(160, c0, k, d);
    rc = req_count;
    access(37, p, k, d);
    chk(k > last_beat_cyc, "R8 old line stalls during fill", k, last_beat_cyc + 1);
    chk(req_count == rc + 1 && last_req_addr == 37, "R8 old line misses after", last_req_addr, 37);
    chk(d == mdata(37), "R8 data", d, mdata(37));
    wait_idle();

    // Sweep all offsets in both modes on idx3
    for (int m = 0; m < 2; m++) begin
      for (int o = 0; o < 8; o++) begin
        int a, ea, el;
        wrap_en = m[0];
        a  = ((6 + m * 8 + o) << 5) | (3 << 3) | o;
        ea = m ? a : (a & ~7);
        el = 1 + LAT + (m ? 0 : o);
        access(a, c0, k, d);
        chk(last_req_addr == ea, "R2 R3 sweep address", last_req_addr, ea);
        chk(k - c0 == el, "R5 sweep latency", k - c0, el);
        chk(d == mdata(a), "R4 sweep data", d, mdata(a));
        wait_idle();
        access(a ^ 4, p, k, d);
        chk(k == p && d == mdata(a ^ 4), "R7 sweep line complete", k, p);
        wait_idle();
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule